// File: doc/BRIEF.md
# Debug mode entry/exit controller

This block decides, cycle by cycle, whether a microcontroller core is held in debug mode. It watches a one-bit control register that a debug host writes, a breakpoint strobe from the core and the enable that lets breakpoints stop the core, an external active-low debug pin, and the chip's reset sources: power-on, brownout and the external reset pin. When reset ends, the level of the debug pin decides whether the core starts out in debug mode.

While debug mode is active, the block stalls the core's instruction fetch. If the core is halted, it asks the core to leave HALT. If the watchdog is enabled, it sends the watchdog a refresh pulse at a fixed interval so the watchdog never times out. Separately, when the core is in STOP, a low level on the debug pin makes the block request a full system reset. The debug status bit can be read back and always shows the current mode.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: A host write with data 1 (`host_wr`=1, `host_wdata`=1) enters debug mode. `dbg_active` reads 1 from the cycle after the write.
- R2: A breakpoint strobe enters debug mode only when `brk_en`=1. With `brk_en`=0 the strobe leaves `dbg_active` unchanged.
- R3: In the first cycle in which no reset is active (block reset released and no reset source asserted), the synchronized debug pin is sampled. If it is low (pin value 0), debug mode is entered. If it is high, the block stays out of debug mode.
- R4: A host write with data 0 leaves debug mode from the next cycle, unless an entry event occurs in the same cycle.
- R5: A power-on event, a brownout event or the external reset pin at 0 clears `dbg_active` in the next cycle. Reset has priority over every entry event.
- R6: `sys_rst_req` is 1 exactly when `core_stopped`=1 and the debug pin, after a two-flop synchronizer, reads 0.
- R7: `fetch_stall` is 1 exactly when debug mode is active.
- R8: `halt_exit_req` is 1 exactly when debug mode is active and `core_halted`=1.
- R9: While debug mode is active and `wdt_en`=1, `wdt_refresh` pulses for one cycle once every REFRESH_DIV cycles. The first pulse comes REFRESH_DIV cycles after the condition starts. At all other times `wdt_refresh` is 0.
- R10: If a host write of 0 and an enabled breakpoint strobe arrive in the same cycle, entry wins and `dbg_active` is 1 in the next cycle.
- R11: `dbg_active` is 0 while `rst_n` is low. It changes only in the cycle after an entry, exit or reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_evt | input | 1 | Power-on reset event, active high |
| bor_evt | input | 1 | Brownout reset event, active high |
| rst_pin_n | input | 1 | External reset pin (already synchronized), active low |
| dbg_pin_n | input | 1 | Asynchronous debug pin, active low |
| host_wr | input | 1 | Host write strobe to the debug-mode control bit |
| host_wdata | input | 1 | Value written to the debug-mode control bit |
| brk_strobe | input | 1 | Core executed a breakpoint instruction |
| brk_en | input | 1 | Breakpoints enter debug mode when 1 |
| core_halted | input | 1 | Core is in HALT |
| core_stopped | input | 1 | Core is in STOP |
| wdt_en | input | 1 | Watchdog is enabled |
| fetch_stall | output | 1 | Stall the core's instruction fetch |
| wdt_refresh | output | 1 | One-cycle watchdog refresh pulse |
| halt_exit_req | output | 1 | Request that the core leave HALT |
| sys_rst_req | output | 1 | Request a full system reset |
| dbg_active | output | 1 | Debug-mode status bit |

## Verification
The assertions check the following on every cycle:
- host and breakpoint entry take effect one cycle later;
- a host clear exits;
- a reset source always wins;
- entry wins over a same-cycle clear;
- the status stays put when there is no event;
- a refresh pulse never appears outside an active, enabled debug mode and is never followed by another pulse in the next cycle.

Only the bench scenarios can show:
- that the pin level at reset release chooses the start-up mode, including the two-cycle synchronizer delay;
- that the wake-reset request follows the pin only while the core is in STOP;
- the exact spacing and phase of the refresh pulses.

// File: rtl/dbg_pkg.sv
// Package dbg_pkg: types shared by the debug-mode controller.
// Assumes nothing beyond the users of dbg_evt_t agreeing on its fields.
package dbg_pkg;

    // Events for one cycle, decoded by the top and used by the mode register.
    typedef struct packed {
        logic rst;   // some reset source is active
        logic set;   // some entry event
        logic clr;   // host clear
    } dbg_evt_t;

endpackage

// File: rtl/dbg_sync.sv
// Module dbg_sync: multi-flop synchronizer for one asynchronous level.
// It assumes the input is a slowly changing level.
// The flops have no reset, so they still track the pin while the block is held in reset.
module dbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dbg_mode_fsm.sv
// Module dbg_mode_fsm: holds the debug-mode state and the reset-release tracker.
// Priority is reset first, then entry, then clear.
// A release event occurs in the first cycle with no reset after a reset was seen.
module dbg_mode_fsm
    import dbg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dbg_evt_t evt,
    input  logic     pin_low,
    output logic     release_evt,
    output logic     active
);
    logic rst_hold;
    logic set_all;

    assign release_evt = rst_hold & ~evt.rst;
    assign set_all     = evt.set | (release_evt & pin_low);

    // Remember that a reset was active, so that its release can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_hold <= 1'b1;
        else        rst_hold <= evt.rst;
    end

    // Mode register with priority reset > entry > clear.
    always_ff @(posedge clk) begin
        if (!rst_n || evt.rst) active <= 1'b0;
        else if (set_all)      active <= 1'b1;
        else if (evt.clr)      active <= 1'b0;
    end
endmodule

// File: rtl/dbg_wdt_refresh.sv
// Module dbg_wdt_refresh: makes the periodic watchdog refresh pulse in debug mode.
// The counter runs only while run=1 and clears otherwise.
// The pulse comes in the cycle the counter reaches DIV-1. Assumes DIV >= 2.
module dbg_wdt_refresh #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic pulse
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign pulse = run & (cnt == LAST);

    // Count run cycles modulo DIV; clear when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (pulse)     cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dbg_mode_ctrl.sv
// Module dbg_mode_ctrl: top of the debug-mode controller.
// Assumes por_evt, bor_evt, rst_pin_n and all core/host inputs are synchronous to clk.
// Only dbg_pin_n is asynchronous and is synchronized here.
module dbg_mode_ctrl
    import dbg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REFRESH_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_evt,
    input  logic bor_evt,
    input  logic rst_pin_n,
    input  logic dbg_pin_n,
    input  logic host_wr,
    input  logic host_wdata,
    input  logic brk_strobe,
    input  logic brk_en,
    input  logic core_halted,
    input  logic core_stopped,
    input  logic wdt_en,
    output logic fetch_stall,
    output logic wdt_refresh,
    output logic halt_exit_req,
    output logic sys_rst_req,
    output logic dbg_active
);
    dbg_evt_t evt;
    logic     pin_s;
    logic     pin_low;
    logic     release_evt;
    logic     active;

    dbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (dbg_pin_n),
        .q_sync  (pin_s)
    );

    assign pin_low = ~pin_s;

    // Decode this cycle's reset, entry and clear events.
    always_comb begin
        evt.rst = por_evt | bor_evt | ~rst_pin_n;
        evt.set = (host_wr & host_wdata) | (brk_strobe & brk_en);
        evt.clr = host_wr & ~host_wdata;
    end

    dbg_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .pin_low     (pin_low),
        .release_evt (release_evt),
        .active      (active)
    );

    dbg_wdt_refresh #(.DIV(REFRESH_DIV)) u_wdt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active & wdt_en),
        .pulse (wdt_refresh)
    );

    assign dbg_active    = active;
    assign fetch_stall   = active;
    assign halt_exit_req = active & core_halted;
    assign sys_rst_req   = core_stopped & pin_low;
endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
// Module dbg_mode_ctrl_chk: property checker attached to dbg_mode_ctrl by bind.
// It only observes; it drives nothing back into the design.
module dbg_mode_ctrl_chk #(
    parameter int REFRESH_DIV = 16
) (
    input logic clk,
    input logic rst_n,
    input logic por_evt,
    input logic bor_evt,
    input logic rst_pin_n,
    input logic host_wr,
    input logic host_wdata,
    input logic brk_strobe,
    input logic brk_en,
    input logic wdt_en,
    input logic wdt_refresh,
    input logic dbg_active,
    input logic release_evt,
    input logic pin_low
);
    logic rsrc;
    logic hset;
    logic bset;
    logic hclr;
    logic any_evt;

    assign rsrc    = por_evt | bor_evt | ~rst_pin_n;
    assign hset    = host_wr & host_wdata;
    assign bset    = brk_strobe & brk_en;
    assign hclr    = host_wr & ~host_wdata;
    assign any_evt = rsrc | hset | bset | hclr | (release_evt & pin_low);

    assert_host_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hset && !rsrc |=> dbg_active);

    assert_brk_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bset && !rsrc |=> dbg_active);

    assert_host_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hclr && !bset && !rsrc && !(release_evt && pin_low) |=> !dbg_active);

    assert_reset_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsrc |=> !dbg_active);

    assert_refresh_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_refresh |-> dbg_active && wdt_en);

    generate
        if (REFRESH_DIV > 1) begin : g_spacing
            assert_refresh_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
                wdt_refresh |=> !wdt_refresh);
        end
    endgenerate

    assert_entry_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hclr && bset && !rsrc |=> dbg_active);

    assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> $stable(dbg_active));
endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk #(.REFRESH_DIV(REFRESH_DIV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_evt     (por_evt),
    .bor_evt     (bor_evt),
    .rst_pin_n   (rst_pin_n),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .brk_strobe  (brk_strobe),
    .brk_en      (brk_en),
    .wdt_en      (wdt_en),
    .wdt_refresh (wdt_refresh),
    .dbg_active  (dbg_active),
    .release_evt (release_evt),
    .pin_low     (pin_low)
);

// File: tb/test_dbg_mode_ctrl.sv
// Bench for dbg_mode_ctrl.
// A behavioural reference model is compared with the design on every cycle,
// and the scenarios add their own checks.
module test_dbg_mode_ctrl;
    localparam int DIV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_evt = 0, bor_evt = 0, rst_pin_n = 1, dbg_pin_n = 1;
    logic host_wr = 0, host_wdata = 0, brk_strobe = 0, brk_en = 0;
    logic core_halted = 0, core_stopped = 0, wdt_en = 0;
    logic fetch_stall, wdt_refresh, halt_exit_req, sys_rst_req, dbg_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    dbg_mode_ctrl #(.REFRESH_DIV(DIV)) i_dbg_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bor_evt(bor_evt),
        .rst_pin_n(rst_pin_n), .dbg_pin_n(dbg_pin_n), .host_wr(host_wr),
        .host_wdata(host_wdata), .brk_strobe(brk_strobe), .brk_en(brk_en),
        .core_halted(core_halted), .core_stopped(core_stopped), .wdt_en(wdt_en),
        .fetch_stall(fetch_stall), .wdt_refresh(wdt_refresh),
        .halt_exit_req(halt_exit_req), .sys_rst_req(sys_rst_req),
        .dbg_active(dbg_active)
    );

    always #5 clk = ~clk;

    // Reference model state.
    bit pin_hist[$] = '{1'b1, 1'b1};   // [0] newest, [1] synchronized
    bit m_inrst = 1;                    // a reset was seen and is not yet released
    bit m_dbg = 0;
    int m_cnt = 0;

    // Advance the model by one clock, following the requirements.
    always @(posedge clk) begin
        bit rs, entry, clear, rel, pl;
        pl    = !pin_hist[1];
        rs    = por_evt || bor_evt || !rst_pin_n;
        entry = (host_wr && host_wdata) || (brk_strobe && brk_en);
        clear = host_wr && !host_wdata;
        rel   = m_inrst && !rs;
        if (!rst_n) begin
            m_dbg = 0; m_inrst = 1; m_cnt = 0;
        end else begin
            if (m_dbg && wdt_en) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
            else m_cnt = 0;
            if (rs) m_dbg = 0;
            else if (entry || (rel && pl)) m_dbg = 1;
            else if (clear) m_dbg = 0;
            m_inrst = rs;
        end
        pin_hist.push_front(dbg_pin_n);
        void'(pin_hist.pop_back());
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model just before each rising edge.
    always @(negedge clk) begin
        #4;
        if (!done) begin
            chk(dbg_active, m_dbg, "R11 status");
            chk(fetch_stall, m_dbg, "R7 stall");
            chk(halt_exit_req, m_dbg && core_halted, "R8 halt exit");
            chk(sys_rst_req, core_stopped && !pin_hist[1], "R6 system reset");
            chk(wdt_refresh, m_dbg && wdt_en && (m_cnt == DIV - 1), "R9 refresh");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_host(input logic v);
        @(negedge clk); host_wr = 1; host_wdata = v;
        @(negedge clk); host_wr = 0;
        #4;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int pulses;
        cyc(5);
        #4 chk(dbg_active, 1'b0, "R11 reset state");
        @(negedge clk); rst_n = 1;
        cyc(2); #4 chk(dbg_active, 1'b0, "R3 pin high at release");

        pulse_host(1); chk(dbg_active, 1'b1, "R1 host set");
        core_halted = 1; wdt_en = 1;
        pulses = 0;
        repeat (3 * DIV) begin @(negedge clk); #4 if (wdt_refresh) pulses++; end
        checks++;
        if (pulses != 3) begin
            errors++;
            $display("FAIL R9 pulse count actual=%0d expected=3", pulses);
        end
        pulse_host(0); chk(dbg_active, 1'b0, "R4 host clear");
        core_halted = 0;

        @(negedge clk); brk_strobe = 1; brk_en = 0;
        @(negedge clk); brk_strobe = 0; #4 chk(dbg_active, 1'b0, "R2 disabled brk ignored");
        @(negedge clk); brk_strobe = 1; brk_en = 1;
        @(negedge clk); brk_strobe = 0; #4 chk(dbg_active, 1'b1, "R2 enabled brk");

        @(negedge clk); brk_strobe = 1; host_wr = 1; host_wdata = 0;
        @(negedge clk); brk_strobe = 0; host_wr = 0; #4 chk(dbg_active, 1'b1, "R10 entry wins");

        @(negedge clk); por_evt = 1; host_wr = 1; host_wdata = 1;
        @(negedge clk); por_evt = 0; host_wr = 0; #4 chk(dbg_active, 1'b0, "R5 power-on exit");
        pulse_host(1);
        @(negedge clk); bor_evt = 1;
        @(negedge clk); bor_evt = 0; #4 chk(dbg_active, 1'b0, "R5 brownout exit");
        pulse_host(1);
        @(negedge clk); rst_pin_n = 0; dbg_pin_n = 0;
        cyc(4); #4 chk(dbg_active, 1'b0, "R5 reset pin held");
        @(negedge clk); rst_pin_n = 1;
        @(negedge clk); #4 chk(dbg_active, 1'b1, "R3 pin low at release");

        pulse_host(0);
        cyc(2); #4 chk(sys_rst_req, 1'b0, "R6 not stopped");
        @(negedge clk); core_stopped = 1;
        #4 chk(sys_rst_req, 1'b1, "R6 stopped with pin low");
        @(negedge clk); dbg_pin_n = 1;
        cyc(2); #4 chk(sys_rst_req, 1'b0, "R6 pin high after sync");
        core_stopped = 0;

        @(negedge clk); rst_n = 0; dbg_pin_n = 0;
        cyc(4); #4 chk(dbg_active, 1'b0, "R11 held in reset");
        @(negedge clk); rst_n = 1;
        @(negedge clk); #4 chk(dbg_active, 1'b1, "R3 block reset release pin low");
        dbg_pin_n = 1;
        cyc(4);
        finish_run();
    end
endmodule